// File: doc/BRIEF.md
# Minimum Pulse Width Compensator

This block sits after the per-phase duration calculation of a three-level modulator. It keeps every phase leg's on-time away from widths the power devices cannot switch cleanly. Each PWM period it receives one on-time per phase, together with the period length and two configurable bounds. The lower bound is the shortest allowed active pulse. The upper bound is the longest allowed active pulse, which is the same as requiring a minimum gap before the period ends.

A phase is narrow in two cases. Its on-time may be nonzero but below the lower bound, which gives a short active pulse. Or its on-time may exceed the upper bound while staying short of the full period, which gives a short gap. A zero or full-period on-time means the leg is clamped, and a clamped leg is never narrow.

When any phase is narrow, the block shifts all phases by one common offset, which acts like a zero-sequence adjustment. It can either add the offset or subtract it. The two options move the midpoint current differently, so an input picks which option is tried first. The other option is tried next. If neither option puts every phase in an allowed width, the on-times pass through unchanged and a failure code is reported. The result and its code appear one clock after the inputs.

Top module: `mpw_comp`

## Requirements
- R1: While `rst_n` is low at a clock edge, `dur_o` becomes all zeros and `corr_o` becomes 0.
- R2: An on-time d is allowed when d = 0, d = Ts, or Tmin ≤ d ≤ Tmax. When every phase is allowed, the next cycle shows `dur_o` equal to `dur_i` and `corr_o` = 0 (none).
- R3: The add offset is the largest need over the narrow phases. A short-pulse phase needs Tmin − d, and a short-gap phase needs Ts − d. Output code 1 (added) means every output equals its input plus this offset.
- R4: The subtract offset is the largest need over the narrow phases. A short-pulse phase needs d, and a short-gap phase needs d − Tmax. Output code 2 (subtracted) means every output equals its input minus this offset.
- R5: A correction is usable only if every shifted phase stays within 0..Ts and lands in the allowed set of R2. A phase that is already allowed must also remain allowed after the shift.
- R6: With `sel_sub_i` = 0, the add correction is used if it is usable, and otherwise the subtract correction. With `sel_sub_i` = 1, the subtract correction is tried first and the add correction second.
- R7: When a phase is narrow and neither correction is usable, `dur_o` equals `dur_i` and `corr_o` = 3 (failed).
- R8: Under code 1 or 2, every output on-time is in the allowed set, and all phases are shifted by the same amount.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_sub_i | input | 1 | 0: try adding first; 1: try subtracting first |
| ts_i | input | W | PWM period length in ticks |
| tmin_i | input | W | Shortest allowed nonzero on-time |
| tmax_i | input | W | Longest allowed on-time short of the full period |
| dur_i | input | NPH×W | Per-phase on-times, phase 0 in the low bits |
| dur_o | output | NPH×W | Compensated per-phase on-times |
| corr_o | output | 2 | 0 none, 1 added, 2 subtracted, 3 failed |

## Verification
The bench sweeps one phase across the whole period while the other two phases sit at mid-scale, near a bound, or clamped at 0 and Ts. It repeats this for both preference settings and two bound configurations. The sweep reaches the edges of the narrow bands: one tick above zero, exactly at Tmin and Tmax, and one tick short of Ts. A design that treated those edge values as the wrong class would either pass a narrow width through or needlessly shift a clean period.

The clamped companions make the preferred correction push another phase past 0 or Ts. This tests whether the design falls back to the other correction, or reports failure when both are blocked. The bench also catches a design that computes a correction which creates a new narrow pulse in a previously clean phase, because that output falls outside the allowed set.

// File: rtl/mpw_pkg.sv
// Shared types for the minimum pulse width compensator.
package mpw_pkg;
    typedef enum logic [1:0] {
        CORR_NONE = 2'd0,
        CORR_ADD  = 2'd1,
        CORR_SUB  = 2'd2,
        CORR_FAIL = 2'd3
    } corr_t;
endpackage

// File: rtl/mpw_classify.sv
// Per-phase classifier: flags a narrow on-time and reports how far a common
// upward or downward shift must move it to reach an allowed width.
// Assumes 0 < tmin <= tmax < ts and d <= ts.
module mpw_classify #(
    parameter int W = 8
) (
    input  logic [W-1:0] d_i,
    input  logic [W-1:0] ts_i,
    input  logic [W-1:0] tmin_i,
    input  logic [W-1:0] tmax_i,
    output logic         narrow_o,
    output logic [W-1:0] need_add_o,
    output logic [W-1:0] need_sub_o
);
    logic short_pulse;
    logic short_gap;

    // Purpose: detect the two narrow bands, excluding clamped values.
    always_comb begin
        short_pulse = (d_i != '0) && (d_i < tmin_i);
        short_gap   = (d_i != ts_i) && (d_i > tmax_i);
    end

    // Purpose: distance to the nearest allowed width in each direction.
    always_comb begin
        need_add_o = '0;
        need_sub_o = '0;
        if (short_pulse) begin
            need_add_o = tmin_i - d_i;
            need_sub_o = d_i;
        end else if (short_gap) begin
            need_add_o = ts_i - d_i;
            need_sub_o = d_i - tmax_i;
        end
    end

    assign narrow_o = short_pulse | short_gap;
endmodule

// File: rtl/mpw_shift_check.sv
// Applies one common offset to all phases, in the direction fixed by
// SUBTRACT, and reports whether every shifted phase stays within 0..ts and
// lands on an allowed width (0, ts, or tmin..tmax).
module mpw_shift_check #(
    parameter int W        = 8,
    parameter int NPH      = 3,
    parameter bit SUBTRACT = 1'b0
) (
    input  logic [NPH-1:0][W-1:0] d_i,
    input  logic [W-1:0]          off_i,
    input  logic [W-1:0]          ts_i,
    input  logic [W-1:0]          tmin_i,
    input  logic [W-1:0]          tmax_i,
    output logic [NPH-1:0][W-1:0] res_o,
    output logic                  ok_o
);
    logic [NPH-1:0] good;

    for (genvar i = 0; i < NPH; i++) begin : g_ph
        logic [W:0] v;
        logic       in_rng;
        if (SUBTRACT) begin : g_sub
            // Purpose: downward shift, valid only without borrow.
            always_comb begin
                v      = {1'b0, d_i[i]} - {1'b0, off_i};
                in_rng = (d_i[i] >= off_i);
            end
        end else begin : g_add
            // Purpose: upward shift, valid only up to the period.
            always_comb begin
                v      = {1'b0, d_i[i]} + {1'b0, off_i};
                in_rng = (v <= {1'b0, ts_i});
            end
        end
        // Purpose: shifted value must be clamped or within the width bounds.
        always_comb begin
            good[i] = in_rng && ((v == '0) || (v == {1'b0, ts_i}) ||
                      ((v >= {1'b0, tmin_i}) && (v <= {1'b0, tmax_i})));
        end
        assign res_o[i] = v[W-1:0];
    end

    assign ok_o = &good;
endmodule

// File: rtl/mpw_comp.sv
// Minimum pulse width compensator, top level. Classifies each phase, builds
// the largest needed add and subtract offsets, checks both, picks one by
// preference with fallback, and registers the result (one cycle latency).
// Assumes 0 < tmin <= tmax < ts and every input on-time <= ts.
module mpw_comp
    import mpw_pkg::*;
#(
    parameter int W   = 8,
    parameter int NPH = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sel_sub_i,
    input  logic [W-1:0]          ts_i,
    input  logic [W-1:0]          tmin_i,
    input  logic [W-1:0]          tmax_i,
    input  logic [NPH-1:0][W-1:0] dur_i,
    output logic [NPH-1:0][W-1:0] dur_o,
    output logic [1:0]            corr_o
);
    logic [NPH-1:0]          narrow;
    logic [NPH-1:0][W-1:0]   need_add;
    logic [NPH-1:0][W-1:0]   need_sub;
    logic [W-1:0]            off_add;
    logic [W-1:0]            off_sub;
    logic [NPH-1:0][W-1:0]   res_add;
    logic [NPH-1:0][W-1:0]   res_sub;
    logic                    ok_add;
    logic                    ok_sub;
    corr_t                   corr_n;
    corr_t                   corr_q;
    logic [NPH-1:0][W-1:0]   dur_n;
    logic [NPH-1:0][W-1:0]   dur_q;
    logic                    past_ok;

    for (genvar i = 0; i < NPH; i++) begin : g_cls
        mpw_classify #(.W(W)) u_cls (
            .d_i       (dur_i[i]),
            .ts_i      (ts_i),
            .tmin_i    (tmin_i),
            .tmax_i    (tmax_i),
            .narrow_o  (narrow[i]),
            .need_add_o(need_add[i]),
            .need_sub_o(need_sub[i])
        );
    end

    // Purpose: largest need over all phases, per direction.
    always_comb begin
        off_add = '0;
        off_sub = '0;
        for (int i = 0; i < NPH; i++) begin
            if (need_add[i] > off_add) off_add = need_add[i];
            if (need_sub[i] > off_sub) off_sub = need_sub[i];
        end
    end

    mpw_shift_check #(.W(W), .NPH(NPH), .SUBTRACT(1'b0)) u_chk_add (
        .d_i   (dur_i),
        .off_i (off_add),
        .ts_i  (ts_i),
        .tmin_i(tmin_i),
        .tmax_i(tmax_i),
        .res_o (res_add),
        .ok_o  (ok_add)
    );

    mpw_shift_check #(.W(W), .NPH(NPH), .SUBTRACT(1'b1)) u_chk_sub (
        .d_i   (dur_i),
        .off_i (off_sub),
        .ts_i  (ts_i),
        .tmin_i(tmin_i),
        .tmax_i(tmax_i),
        .res_o (res_sub),
        .ok_o  (ok_sub)
    );

    // Purpose: choose the correction by preference, fall back, else fail.
    always_comb begin
        corr_n = CORR_NONE;
        dur_n  = dur_i;
        if (|narrow) begin
            if (sel_sub_i ? ok_sub : ok_add) begin
                corr_n = sel_sub_i ? CORR_SUB : CORR_ADD;
                dur_n  = sel_sub_i ? res_sub : res_add;
            end else if (sel_sub_i ? ok_add : ok_sub) begin
                corr_n = sel_sub_i ? CORR_ADD : CORR_SUB;
                dur_n  = sel_sub_i ? res_add : res_sub;
            end else begin
                corr_n = CORR_FAIL;
            end
        end
    end

    // Purpose: output register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dur_q   <= '0;
            corr_q  <= CORR_NONE;
            past_ok <= 1'b0;
        end else begin
            dur_q   <= dur_n;
            corr_q  <= corr_n;
            past_ok <= 1'b1;
        end
    end

    assign dur_o  = dur_q;
    assign corr_o = corr_q;

    p_none_passes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && corr_q == CORR_NONE) |-> (dur_q == $past(dur_i)));

    p_fail_passes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && corr_q == CORR_FAIL) |-> (dur_q == $past(dur_i)));

    for (genvar i = 0; i < NPH; i++) begin : g_asrt
        p_sub_not_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (past_ok && corr_q == CORR_SUB) |-> (dur_q[i] <= $past(dur_i[i])));

        p_add_not_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (past_ok && corr_q == CORR_ADD) |-> (dur_q[i] >= $past(dur_i[i])));

        p_common_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (past_ok && (corr_q == CORR_ADD || corr_q == CORR_SUB)) |->
            ((dur_q[i] - $past(dur_i[i])) == (dur_q[0] - $past(dur_i[0]))));

        p_out_allowed_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (past_ok && (corr_q == CORR_ADD || corr_q == CORR_SUB)) |->
            ((dur_q[i] == '0) || (dur_q[i] == $past(ts_i)) ||
             ((dur_q[i] >= $past(tmin_i)) && (dur_q[i] <= $past(tmax_i)))));
    end
endmodule

// File: tb/tb_mpw_comp.sv
`timescale 1ns/1ps
module tb_mpw_comp;
    localparam int W   = 8;
    localparam int NPH = 3;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  sel_sub_i = 1'b0;
    logic [W-1:0]          ts_i = 8'd100;
    logic [W-1:0]          tmin_i = 8'd10;
    logic [W-1:0]          tmax_i = 8'd90;
    logic [NPH-1:0][W-1:0] dur_i = '0;
    logic [NPH-1:0][W-1:0] dur_o;
    logic [1:0]            corr_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    mpw_comp #(.W(W), .NPH(NPH)) dut (
        .clk(clk), .rst_n(rst_n), .sel_sub_i(sel_sub_i),
        .ts_i(ts_i), .tmin_i(tmin_i), .tmax_i(tmax_i),
        .dur_i(dur_i), .dur_o(dur_o), .corr_o(corr_o)
    );

    always #4 clk = ~clk;

    function automatic bit allowed(int v, int ts, int lo, int hi);
        return (v == 0) || (v == ts) || (v >= lo && v <= hi);
    endfunction

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Reference: apply the requirements arithmetically to one vector.
    task automatic apply(int a, int b, int c, int sel, int ts, int lo, int hi);
        int d[3];
        int e[3];
        int up, dn, code, pref;
        bit any, ok_up, ok_dn;
        string tag;
        d[0] = a; d[1] = b; d[2] = c;
        up = 0; dn = 0; any = 0;
        for (int i = 0; i < 3; i++) begin
            if (d[i] > 0 && d[i] < lo) begin
                any = 1;
                if (lo - d[i] > up) up = lo - d[i];
                if (d[i] > dn) dn = d[i];
            end else if (d[i] > hi && d[i] < ts) begin
                any = 1;
                if (ts - d[i] > up) up = ts - d[i];
                if (d[i] - hi > dn) dn = d[i] - hi;
            end
        end
        ok_up = 1; ok_dn = 1;
        for (int i = 0; i < 3; i++) begin
            if (d[i] + up > ts || !allowed(d[i] + up, ts, lo, hi)) ok_up = 0;
            if (d[i] - dn < 0  || !allowed(d[i] - dn, ts, lo, hi)) ok_dn = 0;
        end
        pref = sel ? 2 : 1;
        if (!any) code = 0;
        else if (sel ? ok_dn : ok_up) code = pref;
        else if (sel ? ok_up : ok_dn) code = sel ? 1 : 2;
        else code = 3;
        for (int i = 0; i < 3; i++)
            e[i] = (code == 1) ? d[i] + up : (code == 2) ? d[i] - dn : d[i];

        @(negedge clk);
        sel_sub_i = sel[0];
        ts_i = ts[W-1:0]; tmin_i = lo[W-1:0]; tmax_i = hi[W-1:0];
        dur_i[0] = a[W-1:0]; dur_i[1] = b[W-1:0]; dur_i[2] = c[W-1:0];
        @(negedge clk);
        // R5 covers fallback choice; R6 the preferred choice.
        if (code != 0 && code != pref) check("R5 code", int'(corr_o), code);
        else check("R6 code", int'(corr_o), code);
        tag = (code == 0) ? "R2 value" : (code == 1) ? "R3 value" :
              (code == 2) ? "R4 value" : "R7 value";
        for (int i = 0; i < 3; i++) begin
            check(tag, int'(dur_o[i]), e[i]);
            if (code == 1 || code == 2)
                check("R8 allowed", int'(allowed(int'(dur_o[i]), ts, lo, hi)), 1);
        end
    endtask

    initial begin
        int bs[4];
        int cs[4];
        bs[0] = 50; cs[0] = 50;
        bs[1] = 85; cs[1] = 15;
        bs[2] = 0;  cs[2] = 100;
        bs[3] = 5;  cs[3] = 95;
        dur_i[0] = 8'd33; dur_i[1] = 8'd7; dur_i[2] = 8'd99;
        repeat (3) @(negedge clk);
        check("R1 reset dur0", int'(dur_o[0]), 0);
        check("R1 reset dur1", int'(dur_o[1]), 0);
        check("R1 reset dur2", int'(dur_o[2]), 0);
        check("R1 reset code", int'(corr_o), 0);
        rst_n = 1'b1;
        for (int cfg = 0; cfg < 2; cfg++)
            for (int p = 0; p < 4; p++)
                for (int s = 0; s < 2; s++)
                    for (int a = 0; a <= 100; a++)
                        if (cfg == 0) apply(a, bs[p], cs[p], s, 100, 10, 90);
                        else apply(a, bs[p], cs[p], s, 100, 20, 70);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule